// File: doc/BRIEF.md
# Microword Predecoder

This block looks at one microprogram word and sorts it into a single decoded operation, ready for an execution stage to consume. It checks the word's parity, recognises which instruction class the word belongs to, and reports the results. The classes overlap, so they are tested in a fixed order. The block also pulls scattered bit fields together into a 16-bit branch target, a 16-bit literal or an 8-bit immediate. It gives the operand-fetch and carry-preset hints and a small signed program-counter adjustment. Words with bad parity or an illegal encoding are flagged as such.

The input port is wider than the 24-bit microword. Only the low 24 bits take part in decoding. The current microprogram address is an input as well, because a page branch keeps its upper bits. With `OUT_REG` set (the default), every result is registered and appears one clock after the word is presented. With `OUT_REG` clear, the results are purely combinational.

Top module: `uc_predecode`

## Requirements
- R1: Input bits above bit 23 have no effect on any output.
- R2: A word whose bits [23:0] have even parity decodes as op UOP_PERR with perr_o=1 and illegal_o=0. All fetch flags, cy_preset_o, value_o and pc_adj_o are 0 in that case, whatever the other fields hold.
- R3: The classes are tested in this order: parity error first. Next is the literal load, `(w & 0x790000) == 0x190000`. Next is the short op, `(w & 0x618000) == 0x018000`. Next is the shift, `(w & 0x71C000) == 0x004000`. Any other word is decoded from its opcode in bits [22:18].
- R4: A literal load gives op UOP_LDI and value_o = {w[18:17], w[15:14], w[11:0]}. fetch_b_o is set exactly when w[13:12] equals 1.
- R5: Page branches give value_o = {upc[15:10], w[17:8]}. Page branches are opcodes 0x10 to 0x14, 0x16 and 0x18 to 0x1F. Full branches give value_o = {w[7:2], w[17:8]}. Full branches are 0x15 (UOP_CALL) and 0x17 (UOP_JMP).
- R6: Opcodes 0x08 to 0x0F are immediate ALU ops. They set fetch_b_o, and value_o = {8'h00, w[17:14], w[7:4]}.
- R7: The destination field is w[11:8]. Values 10 and 11 are illegal for register ALU, shift and immediate forms. Value 9 is also illegal for the extended forms, which set fetch_x_o only. A register ALU op is extended when w[17]=1, and a shift is extended when w[17]=1. A register branch is extended when w[18]=1, for opcodes 0x10 to 0x13.
- R8: Opcodes 0x00 to 0x07 are register ALU ops and are illegal when w[16]=1. Opcodes 0x00 to 0x06 set cy_preset_o when w[15:14] is 2 or 3. Opcode 0x07 never sets it.
- R9: Short ops select their sub-operation with w[20:17]. Sub-operations 0, 1 and 2 are the transfer-style forms. For these, pc_adj_o comes from the index {w[14], w[10:9]}, read in the order 0, +1, +2, +3, 0, -1, -2, -3. An unknown sub-operation, or a word that breaks its sub-operation's fixed bits, is illegal.
- R10: Plain register ALU ops, plain shifts and register branches take pc_adj_o from the A field w[7:4]. Values 8, 9 and 15 give -1, values 12 to 14 give +1, and every other value gives 0.
- R11: An illegal word gives op UOP_BAD and illegal_o=1. All fetch flags, cy_preset_o, value_o, pc_adj_o and perr_o are 0.
- R12: With OUT_REG=1, reset clears every output to 0 (op UOP_IDLE). After reset, each output reflects the word present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| ucw | input | IN_W | Microword; only bits [23:0] are decoded |
| upc | input | 16 | Address of the word being decoded |
| uop_o | output | 6 | Decoded operation code (uop_e) |
| fetch_a_o | output | 1 | Fetch the A operand |
| fetch_b_o | output | 1 | Fetch the B operand |
| fetch_x_o | output | 1 | Extended operand fetch |
| cy_preset_o | output | 1 | Carry is preset before execution |
| value_o | output | 16 | Branch target, literal or immediate |
| pc_adj_o | output | 3 | Signed adjustment of the data address |
| perr_o | output | 1 | Control-store parity error |
| illegal_o | output | 1 | Illegal encoding |

## Verification
Every output, including the parity and illegal flags, is due exactly one rising edge after the word and address are driven. The decode path has no further state. The driver changes the inputs on the falling edge and queues the expected result. The monitor pops the queue 1 ns after the next rising edge, so each comparison lands in the single cycle where that word's result is valid. The reset value is checked while reset is held, before any word has been clocked in.

// File: rtl/uc_pkg.sv
package uc_pkg;

  localparam int WORD_W = 24;
  localparam int ADDR_W = 16;
  localparam int ADJ_W  = 3;

  typedef enum logic [5:0] {
    UOP_IDLE, UOP_PERR, UOP_BAD,
    UOP_OR, UOP_XOR, UOP_AND, UOP_SUBC, UOP_DADC, UOP_DSBC, UOP_ADDC, UOP_MUL,
    UOP_ORX, UOP_XORX, UOP_ANDX, UOP_SUBCX, UOP_DADCX, UOP_DSBCX, UOP_ADDCX, UOP_MULX,
    UOP_SHF, UOP_SHFX,
    UOP_ORI, UOP_XORI, UOP_ANDI, UOP_ADDI, UOP_DADCI, UOP_DSBCI, UOP_ADDCI, UOP_MULI,
    UOP_A2P, UOP_P2A, UOP_XCHPA, UOP_P2S, UOP_S2P, UOP_RDCM, UOP_WRCM, UOP_RET, UOP_IOCTL,
    UOP_LDI,
    UOP_BRT, UOP_BRF, UOP_BRM_EQ, UOP_BRM_NE,
    UOP_BLT, UOP_BLTX, UOP_BLE, UOP_BLEX, UOP_BEQR, UOP_BNER,
    UOP_CALL, UOP_JMP
  } uop_e;

  typedef struct packed {
    uop_e              op;
    logic              fa;
    logic              fb;
    logic              fx;
    logic              cy;
    logic [ADDR_W-1:0] val;
    logic [ADJ_W-1:0]  adj;
    logic              perr;
    logic              ill;
  } dec_t;

  function automatic logic f_odd(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  // A-field driven data address adjustment
  function automatic logic [ADJ_W-1:0] f_pc_adj(input logic [3:0] a);
    if (a == 4'd8 || a == 4'd9 || a == 4'd15) return 3'b111;
    if (a >= 4'd12 && a <= 4'd14)             return 3'b001;
    return 3'b000;
  endfunction

  // transfer-style step: sign in bit 2, magnitude in bits 1:0
  function automatic logic [ADJ_W-1:0] f_step(input logic [2:0] idx);
    logic [ADJ_W-1:0] mag;
    mag = {1'b0, idx[1:0]};
    return idx[2] ? (~mag + 3'd1) : mag;
  endfunction

  function automatic logic [ADDR_W-1:0] f_lit16(input logic [WORD_W-1:0] w);
    return {w[18:17], w[15:14], w[11:0]};
  endfunction

  function automatic logic [7:0] f_imm8(input logic [WORD_W-1:0] w);
    return {w[17:14], w[7:4]};
  endfunction

  function automatic logic [ADDR_W-1:0] f_page(input logic [ADDR_W-1:0] pc,
                                               input logic [WORD_W-1:0] w);
    return {pc[15:10], w[17:8]};
  endfunction

  function automatic logic [ADDR_W-1:0] f_full(input logic [WORD_W-1:0] w);
    return {w[7:2], w[17:8]};
  endfunction

endpackage

// File: rtl/uc_parity_chk.sv
module uc_parity_chk
  import uc_pkg::*;
(
  input  logic [WORD_W-1:0] w,
  output logic              bad
);
  assign bad = ~f_odd(w);
endmodule

// File: rtl/uc_class_sel.sv
module uc_class_sel
  import uc_pkg::*;
(
  input  logic [WORD_W-1:0] w,
  input  logic              par_bad,
  output logic              is_perr,
  output logic              is_ldi,
  output logic              is_mini,
  output logic              is_shf,
  output logic              is_main
);
  logic hit_ldi, hit_mini, hit_shf;

  assign hit_ldi  = (w & 24'h790000) == 24'h190000;
  assign hit_mini = (w & 24'h618000) == 24'h018000;
  assign hit_shf  = (w & 24'h71C000) == 24'h004000;

  // fixed priority among overlapping class patterns
  always_comb begin
    is_perr = 1'b0; is_ldi = 1'b0; is_mini = 1'b0; is_shf = 1'b0; is_main = 1'b0;
    if (par_bad)       is_perr = 1'b1;
    else if (hit_ldi)  is_ldi  = 1'b1;
    else if (hit_mini) is_mini = 1'b1;
    else if (hit_shf)  is_shf  = 1'b1;
    else               is_main = 1'b1;
  end

  // R3: exactly one class claims each known word
  always_comb begin
    if (!$isunknown(w) && !$isunknown(par_bad))
      p_one_class_r3: assert ($countones({is_perr, is_ldi, is_mini, is_shf, is_main}) == 1);
  end
endmodule

// File: rtl/uc_op_decode.sv
module uc_op_decode
  import uc_pkg::*;
(
  input  logic [WORD_W-1:0] w,
  input  logic [ADDR_W-1:0] pc,
  input  logic              is_perr,
  input  logic              is_ldi,
  input  logic              is_mini,
  input  logic              is_shf,
  output dec_t              d
);
  logic [3:0] dst;
  logic [1:0] dd;
  logic [4:0] opc;
  logic       dst_bad, dst_bad_x;
  logic       ill;
  dec_t       raw;

  assign dst       = w[11:8];
  assign dd        = w[13:12];
  assign opc       = w[22:18];
  assign dst_bad   = (dst == 4'd10) || (dst == 4'd11);
  assign dst_bad_x = dst_bad || (dst == 4'd9);

  always_comb begin
    raw    = '0;
    raw.op = UOP_BAD;
    ill    = 1'b0;
    if (is_perr) begin
      raw.op   = UOP_PERR;
      raw.perr = 1'b1;
    end else if (is_ldi) begin
      raw.op  = UOP_LDI;
      raw.fb  = (dd == 2'd1);
      raw.val = f_lit16(w);
    end else if (is_mini) begin
      unique case (w[20:17])
        4'h5: begin raw.op = UOP_A2P;   ill = (w & 24'h7F8000) != 24'h0B8000; raw.fb = dd[1]; end
        4'h0: begin raw.op = UOP_P2A;   ill = (w & 24'h7F8800) != 24'h018000; raw.fb = dd[1];
                    raw.adj = f_step({w[14], w[10:9]}); end
        4'h1: begin raw.op = UOP_XCHPA; ill = (w & 24'h7F8800) != 24'h038000; raw.fb = dd[1];
                    raw.adj = f_step({w[14], w[10:9]}); end
        4'h2: begin raw.op = UOP_P2S;   ill = (w & 24'h7F8800) != 24'h058000; raw.fb = dd[1];
                    raw.adj = f_step({w[14], w[10:9]}); end
        4'h6: begin raw.op = UOP_S2P;   ill = (w & 24'h7F8800) != 24'h0D8000; raw.fb = dd[1]; end
        4'h3: begin
          if ((w & 24'h7F8E00) == 24'h078600)      raw.op = UOP_RDCM;
          else if ((w & 24'h7F8E00) == 24'h078400) raw.op = UOP_WRCM;
          else if ((w & 24'h7F8C00) == 24'h078000) begin raw.op = UOP_RET; raw.fb = dd[1]; end
          else ill = 1'b1;
        end
        4'hB: begin raw.op = UOP_IOCTL; ill = (w & 24'h7FB000) != 24'h178000; end
        default: ill = 1'b1;
      endcase
    end else if (is_shf) begin
      if (w[17]) begin
        raw.op = UOP_SHFX; raw.fx = 1'b1; ill = dst_bad_x;
      end else begin
        raw.op = UOP_SHF; raw.fa = 1'b1; raw.fb = 1'b1; ill = dst_bad;
        raw.adj = f_pc_adj(w[7:4]);
      end
    end else if (opc < 5'h08) begin
      raw.cy = (opc != 5'h07) && w[15];
      ill    = w[16];
      if (w[17]) begin
        raw.op = uop_e'(6'(int'(UOP_ORX) + int'(opc)));
        raw.fx = 1'b1;
        ill    = ill || dst_bad_x;
      end else begin
        raw.op  = uop_e'(6'(int'(UOP_OR) + int'(opc)));
        raw.fa  = 1'b1;
        raw.fb  = 1'b1;
        raw.adj = f_pc_adj(w[7:4]);
        ill     = ill || dst_bad;
      end
    end else if (opc < 5'h10) begin
      raw.op  = uop_e'(6'(int'(UOP_ORI) + int'(opc) - 8));
      raw.fb  = 1'b1;
      raw.val = {8'h00, f_imm8(w)};
      ill     = dst_bad;
    end else begin
      unique case (opc)
        5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h16: begin
          raw.adj = f_pc_adj(w[7:4]);
          raw.val = f_page(pc, w);
          if (opc[0] && opc < 5'h14) begin
            raw.fx = 1'b1;
            raw.op = (opc <= 5'h11) ? UOP_BLTX : UOP_BLEX;
          end else begin
            raw.fa = 1'b1; raw.fb = 1'b1;
            raw.op = (opc <= 5'h11) ? UOP_BLT :
                     (opc <= 5'h13) ? UOP_BLE :
                     (opc == 5'h14) ? UOP_BEQR : UOP_BNER;
          end
        end
        5'h15: begin raw.op = UOP_CALL; raw.val = f_full(w); end
        5'h17: begin raw.op = UOP_JMP;  raw.val = f_full(w); end
        default: begin
          raw.fb  = 1'b1;
          raw.val = f_page(pc, w);
          unique case (opc[2:1])
            2'd0:    raw.op = UOP_BRT;
            2'd1:    raw.op = UOP_BRF;
            2'd2:    raw.op = UOP_BRM_EQ;
            default: raw.op = UOP_BRM_NE;
          endcase
        end
      endcase
    end

    d = raw;
    if (ill) begin
      d     = '0;
      d.op  = UOP_BAD;
      d.ill = 1'b1;
    end
  end
endmodule

// File: rtl/uc_predecode.sv
module uc_predecode
  import uc_pkg::*;
#(
  parameter int IN_W    = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IN_W-1:0]    ucw,
  input  logic [15:0]        upc,
  output logic [5:0]         uop_o,
  output logic               fetch_a_o,
  output logic               fetch_b_o,
  output logic               fetch_x_o,
  output logic               cy_preset_o,
  output logic [15:0]        value_o,
  output logic signed [2:0]  pc_adj_o,
  output logic               perr_o,
  output logic               illegal_o
);
  logic [WORD_W-1:0] word;
  logic par_bad, c_perr, c_ldi, c_mini, c_shf, c_main;
  dec_t comb_d, out_d;

  assign word = ucw[WORD_W-1:0];

  uc_parity_chk u_par (.w(word), .bad(par_bad));

  uc_class_sel u_cls (
    .w(word), .par_bad(par_bad),
    .is_perr(c_perr), .is_ldi(c_ldi), .is_mini(c_mini), .is_shf(c_shf), .is_main(c_main)
  );

  uc_op_decode u_dec (
    .w(word), .pc(upc),
    .is_perr(c_perr), .is_ldi(c_ldi), .is_mini(c_mini), .is_shf(c_shf),
    .d(comb_d)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_d  <= '0;
          primed <= 1'b0;
        end else begin
          out_d  <= comb_d;
          primed <= 1'b1;
        end
      end
      // R2: registered parity flag follows the word of the previous edge
      p_perr_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (perr_o == ~(^$past(ucw[WORD_W-1:0]))));
    end else begin : g_comb
      assign out_d = comb_d;
    end
  endgenerate

  assign uop_o       = out_d.op;
  assign fetch_a_o   = out_d.fa;
  assign fetch_b_o   = out_d.fb;
  assign fetch_x_o   = out_d.fx;
  assign cy_preset_o = out_d.cy;
  assign value_o     = out_d.val;
  assign pc_adj_o    = out_d.adj;
  assign perr_o      = out_d.perr;
  assign illegal_o   = out_d.ill;

  p_perr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> (!fetch_a_o && !fetch_b_o && !fetch_x_o && !cy_preset_o &&
                value_o == 16'h0 && pc_adj_o == 3'sd0 && !illegal_o));

  p_ill_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!fetch_a_o && !fetch_b_o && !fetch_x_o && !cy_preset_o &&
                   value_o == 16'h0 && pc_adj_o == 3'sd0 && !perr_o));

  p_cy_alu_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cy_preset_o |-> (uop_o >= 6'(UOP_OR) && uop_o <= 6'(UOP_ADDCX) &&
                     uop_o != 6'(UOP_MUL)));

  p_ext_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_x_o |-> (!fetch_a_o && !fetch_b_o));

  p_adj_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_adj_o != 3'sd0) |-> (uop_o inside {6'(UOP_P2A), 6'(UOP_XCHPA), 6'(UOP_P2S)} ||
                             (uop_o >= 6'(UOP_OR) && uop_o <= 6'(UOP_MUL)) ||
                             uop_o == 6'(UOP_SHF) ||
                             (uop_o >= 6'(UOP_BLT) && uop_o <= 6'(UOP_BNER))));
endmodule

// File: tb/sim_uc_predecode.sv
module sim_uc_predecode;
  import uc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ucw = '0;
  logic [15:0] upc = '0;
  logic [5:0]  uop_o;
  logic fetch_a_o, fetch_b_o, fetch_x_o, cy_preset_o, perr_o, illegal_o;
  logic [15:0] value_o;
  logic signed [2:0] pc_adj_o;

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;

  dec_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uc_predecode u0 (
    .clk(clk), .rst_n(rst_n), .ucw(ucw), .upc(upc), .uop_o(uop_o),
    .fetch_a_o(fetch_a_o), .fetch_b_o(fetch_b_o), .fetch_x_o(fetch_x_o),
    .cy_preset_o(cy_preset_o), .value_o(value_o), .pc_adj_o(pc_adj_o),
    .perr_o(perr_o), .illegal_o(illegal_o)
  );

  function automatic logic [2:0] adj_of_a(input logic [3:0] a);
    case (a)
      4'd8, 4'd9, 4'd15:   return 3'b111;
      4'd12, 4'd13, 4'd14: return 3'b001;
      default:             return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] step_of(input logic [2:0] i);
    case (i)
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd3: return 3'd3;
      3'd5: return 3'b111;
      3'd6: return 3'b110;
      3'd7: return 3'b101;
      default: return 3'd0;
    endcase
  endfunction

  // reference decoder, restated from the requirements
  function automatic dec_t ref_dec(input logic [31:0] raw, input logic [15:0] pc);
    logic [23:0] w;
    logic [4:0]  op;
    logic [3:0]  c;
    dec_t r;
    bit bad;
    uop_e alu_p[8] = '{UOP_OR, UOP_XOR, UOP_AND, UOP_SUBC, UOP_DADC, UOP_DSBC, UOP_ADDC, UOP_MUL};
    uop_e alu_x[8] = '{UOP_ORX, UOP_XORX, UOP_ANDX, UOP_SUBCX, UOP_DADCX, UOP_DSBCX, UOP_ADDCX, UOP_MULX};
    uop_e imm_n[8] = '{UOP_ORI, UOP_XORI, UOP_ANDI, UOP_ADDI, UOP_DADCI, UOP_DSBCI, UOP_ADDCI, UOP_MULI};
    uop_e msk_n[4] = '{UOP_BRT, UOP_BRF, UOP_BRM_EQ, UOP_BRM_NE};
    w = raw[23:0]; op = w[22:18]; c = w[11:8];
    r = '0; bad = 0;
    if (($countones(w) % 2) == 0) begin
      r.op = UOP_PERR; r.perr = 1; return r;
    end
    if (w[22:19] == 4'b0011 && w[16]) begin
      r.op = UOP_LDI; r.fb = (w[13:12] == 2'b01);
      r.val = {w[18:17], w[15:14], w[11:0]};
    end else if (w[22:21] == 2'b00 && w[16:15] == 2'b11) begin
      case (w[20:17])
        4'h5: begin r.op = UOP_A2P; bad = w[22:15] != 8'h17; r.fb = w[13]; end
        4'h0: begin r.op = UOP_P2A; bad = w[22:15] != 8'h03 || w[11]; r.fb = w[13];
                    r.adj = step_of({w[14], w[10:9]}); end
        4'h1: begin r.op = UOP_XCHPA; bad = w[22:15] != 8'h07 || w[11]; r.fb = w[13];
                    r.adj = step_of({w[14], w[10:9]}); end
        4'h2: begin r.op = UOP_P2S; bad = w[22:15] != 8'h0B || w[11]; r.fb = w[13];
                    r.adj = step_of({w[14], w[10:9]}); end
        4'h6: begin r.op = UOP_S2P; bad = w[22:15] != 8'h1B || w[11]; r.fb = w[13]; end
        4'h3: begin
          if (w[22:15] != 8'h0F) bad = 1;
          else if (w[11:9] == 3'b011) r.op = UOP_RDCM;
          else if (w[11:9] == 3'b010) r.op = UOP_WRCM;
          else if (w[11:10] == 2'b00) begin r.op = UOP_RET; r.fb = w[13]; end
          else bad = 1;
        end
        4'hB: begin r.op = UOP_IOCTL; bad = w[22:15] != 8'h2F || w[13:12] != 2'b00; end
        default: bad = 1;
      endcase
    end else if (w[22:20] == 3'b000 && w[16:14] == 3'b001) begin
      if (w[17]) begin r.op = UOP_SHFX; r.fx = 1; bad = c >= 9 && c <= 11; end
      else begin r.op = UOP_SHF; r.fa = 1; r.fb = 1; r.adj = adj_of_a(w[7:4]);
                 bad = c == 10 || c == 11; end
    end else if (op[4:3] == 2'b00) begin
      r.cy = op != 5'd7 && w[15:14] >= 2;
      bad = w[16];
      if (w[17]) begin r.op = alu_x[op[2:0]]; r.fx = 1; if (c >= 9 && c <= 11) bad = 1; end
      else begin r.op = alu_p[op[2:0]]; r.fa = 1; r.fb = 1; r.adj = adj_of_a(w[7:4]);
                 if (c == 10 || c == 11) bad = 1; end
    end else if (op[4:3] == 2'b01) begin
      r.op = imm_n[op[2:0]]; r.fb = 1; r.val = {8'h00, w[17:14], w[7:4]};
      bad = c == 10 || c == 11;
    end else if (op == 5'h15 || op == 5'h17) begin
      r.op = (op == 5'h15) ? UOP_CALL : UOP_JMP;
      r.val = {w[7:2], w[17:8]};
    end else if (op[4:3] == 2'b11) begin
      r.op = msk_n[op[2:1]]; r.fb = 1; r.val = {pc[15:10], w[17:8]};
    end else begin
      r.val = {pc[15:10], w[17:8]}; r.adj = adj_of_a(w[7:4]);
      case (op)
        5'h10: begin r.op = UOP_BLT;  r.fa = 1; r.fb = 1; end
        5'h11: begin r.op = UOP_BLTX; r.fx = 1; end
        5'h12: begin r.op = UOP_BLE;  r.fa = 1; r.fb = 1; end
        5'h13: begin r.op = UOP_BLEX; r.fx = 1; end
        5'h14: begin r.op = UOP_BEQR; r.fa = 1; r.fb = 1; end
        default: begin r.op = UOP_BNER; r.fa = 1; r.fb = 1; end
      endcase
    end
    if (bad) begin r = '0; r.op = UOP_BAD; r.ill = 1; end
    return r;
  endfunction

  function automatic dec_t mk(input uop_e op, input logic fa, input logic fb,
                              input logic [15:0] val);
    dec_t r;
    r = '0; r.op = op; r.fa = fa; r.fb = fb; r.val = val;
    return r;
  endfunction

  function automatic logic [31:0] fix_par(input logic [31:0] x);
    logic [31:0] y;
    y = x;
    y[23] = ~(^x[22:0]);
    return y;
  endfunction

  task automatic cmp(input dec_t e, input string tag);
    dec_t a;
    a.op = uop_e'(uop_o); a.fa = fetch_a_o; a.fb = fetch_b_o; a.fx = fetch_x_o;
    a.cy = cy_preset_o; a.val = value_o; a.adj = pc_adj_o; a.perr = perr_o; a.ill = illegal_o;
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got op=%0d fa%b fb%b fx%b cy%b val=%h adj=%0d pe%b il%b, want op=%0d fa%b fb%b fx%b cy%b val=%h adj=%0d pe%b il%b",
               tag, a.op, a.fa, a.fb, a.fx, a.cy, a.val, $signed(a.adj), a.perr, a.ill,
               e.op, e.fa, e.fb, e.fx, e.cy, e.val, $signed(e.adj), e.perr, e.ill);
    end
  endtask

  // driver: present a word on the falling edge and queue its expectation
  task automatic drive_exp(input logic [31:0] w, input logic [15:0] pc,
                           input dec_t e, input string tag);
    @(negedge clk);
    ucw = w; upc = pc;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic drive(input logic [31:0] w, input logic [15:0] pc, input string tag);
    drive_exp(w, pc, ref_dec(w, pc), tag);
  endtask

  // monitor: result is due one rising edge after the word
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (running && exp_q.size() > 0) cmp(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang, want completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  logic [23:0] cls_msk[11] = '{24'h790000, 24'h7F8000, 24'h7F8800, 24'h7F8800, 24'h7F8800,
                               24'h7F8800, 24'h7F8C00, 24'h7FB000, 24'h71C000, 24'h610000, 24'h600000};
  logic [23:0] cls_pat[11] = '{24'h190000, 24'h0B8000, 24'h018000, 24'h038000, 24'h058000,
                               24'h0D8000, 24'h078000, 24'h178000, 24'h004000, 24'h000000, 24'h200000};

  initial begin
    dec_t e;
    repeat (3) @(negedge clk);
    // R12: reset state while reset is held
    e = '0;
    cmp(e, "R12 reset");
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;

    e = mk(UOP_LDI, 0, 1, 16'hAABC);
    drive_exp(32'h001D9ABC, 16'h0000, e, "R4 literal packing");
    drive_exp(32'hFF1D9ABC, 16'h1234, e, "R1 upper bits ignored");
    drive_exp(32'h00DD55A8, 16'h4321, mk(UOP_JMP, 0, 0, 16'hA955), "R5 full branch");
    drive_exp(32'h0062F005, 16'hFC12, mk(UOP_BRT, 0, 1, 16'hFEF0), "R5 page branch");
    drive_exp(32'h00268351, 16'h0000, mk(UOP_XORI, 0, 1, 16'h00A5), "R6 immediate");
    drive(32'h00A68351, 16'h0000, "R2 parity flip");
    drive(32'h00998000, 16'h0000, "R3 literal beats short op");
    drive(32'h00800A00, 16'h0000, "R7 dest 10");
    drive(32'h00020900, 16'h0000, "R7 ext dest 9");
    drive(32'h00800900, 16'h0000, "R7 plain dest 9 legal");
    drive(32'h000CC100, 16'h0000, "R8 carry preset");
    drive(32'h009CC100, 16'h0000, "R8 multiply no preset");
    drive(32'h008D0100, 16'h0000, "R8 bit16 illegal");
    drive(32'h0001C600, 16'h0000, "R9 step -3");
    drive(32'h008000C0, 16'h0000, "R10 adj +1");
    drive(32'h008000F0, 16'h0000, "R10 adj -1");
    drive(32'h00098000, 16'h0000, "R11 unknown short op");

    for (int k = 0; k < 11; k++) begin
      for (int n = 0; n < 200; n++) begin
        logic [31:0] w;
        w = $urandom;
        w[23:0] = (w[23:0] & ~cls_msk[k]) | cls_pat[k];
        w = fix_par(w);
        drive(w, 16'($urandom), (k == 0) ? "R4 random literal" :
                                (k < 8)  ? "R9 random short op" :
                                (k == 8) ? "R7 random shift" :
                                (k == 9) ? "R8 random ALU" : "R6 random immediate");
      end
    end
    for (int n = 0; n < 800; n++) begin
      logic [31:0] w;
      w = fix_par($urandom);
      drive(w, 16'($urandom), "R3 random word");
      drive(w ^ 32'h00800000, 16'($urandom), "R2 corrupted parity");
      drive({8'($urandom), w[23:0]}, 16'($urandom), "R1 random upper byte");
    end
    for (int op = 16; op < 32; op++) begin
      logic [31:0] w;
      w = $urandom;
      w[22:18] = 5'(op);
      drive(fix_par(w), 16'($urandom), "R5 branch sweep");
    end
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = 32'h00018000 | (32'(i[2]) << 14) | (32'(i[1:0]) << 9);
      drive(fix_par(w), 16'h0000, "R9 step sweep");
    end
    for (int a = 0; a < 16; a++)
      drive(fix_par(32'h00000100 | (32'(a) << 4)), 16'h0000, "R10 A field sweep");

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule